// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Mapper

This block sits between a handheld console CPU and the memories of a game cartridge. CPU writes anywhere in 0000-7FFF never reach the ROM. They load four small control registers instead: a RAM enable, a 5-bit low bank number, a 2-bit shared bank field and a one-bit banking mode. CPU reads are translated. The ROM window 0000-7FFF becomes a 21-bit physical ROM address, and the external RAM window A000-BFFF becomes a 15-bit physical RAM address with a chip enable.

The 2-bit shared field does one of two jobs, chosen by two static strap inputs. On a large-ROM cartridge it supplies ROM bank bits 6:5. On a large-RAM cartridge it supplies the RAM bank. When the mode bit is set on a large-ROM cartridge, the same field also moves the fixed lower ROM window to bank 00h, 20h, 40h or 60h. The low bank number never reads as zero. Because of that, banks 20h, 40h and 60h cannot be reached through the switchable window, and the mode-1 lower-window remap is the only way to reach them.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, RAM is disabled, the low bank is 1, the shared field is 0 and the mode is 0. Address 4000h therefore gives ROM address 04000h, and address 0000h gives 00000h.
- R2: A write to 0000-1FFF enables RAM when data[3:0] is Ah and disables RAM for any other value. data[7:4] is ignored.
- R3: A write to 2000-3FFF loads the low bank from data[4:0]. data[7:5] is ignored.
- R4: A low bank value of 0 is used as 1 in the 4000-7FFF window.
- R5: A write to 4000-5FFF loads the shared field from data[1:0]. On a large-ROM cartridge the 4000-7FFF bank is {shared, low}, so a request for bank 20h, 40h or 60h gives 21h, 41h or 61h.
- R6: A write to 6000-7FFF loads the mode from data[0].
- R7: In mode 0, the 0000-3FFF window always maps to ROM bank 0.
- R8: In mode 1 on a large-ROM cartridge, the 0000-3FFF window maps to bank shared<<5.
- R9: The 4000-7FFF bank is computed the same way in both modes.
- R10: ram_ce is high only when RAM is enabled and the address lies in A000-BFFF.
- R11: ram_addr is {rbank, addr[12:0]}. rbank is the shared field in mode 1 on a large-RAM cartridge, and 0 in every other case.
- R12: Without the large-ROM strap, ROM bank bits 6:5 are always 0.
- R13: rom_addr[13:0] equals addr[13:0]. Writes at 8000h and above change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| cfg_big_rom | input | 1 | Static strap: cartridge has 1 MB or more of ROM |
| cfg_big_ram | input | 1 | Static strap: cartridge has more than 8 KB of RAM |
| rom_addr | output | 21 | Physical ROM address |
| ram_addr | output | 15 | Physical RAM address |
| ram_ce | output | 1 | RAM chip enable |

## Verification
The hardest case to reach is a mode-1 lower window that points at bank 20h, 40h or 60h. Reaching it takes four writes in order: the large-ROM strap set, a nonzero shared field, a low bank value, and the mode bit. The bench then reads from both windows in that one state. It shows that the lower window moved to shared<<5 while the switchable window still resolves the zero-low request to the +1 bank. Going the other way, the bench clears the mode and checks that the lower window returns to bank 0 without any other register being rewritten.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cfg_big_rom,
  input  logic              cfg_big_ram,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce
);
  localparam int BANK_W = 7;

  logic       ram_on_q;
  logic [4:0] low_q;
  logic [1:0] hi_q;
  logic       mode_q;

  wire cfg_wr = cpu_wr && !cpu_addr[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_on_q <= 1'b0;
      low_q    <= 5'd1;
      hi_q     <= 2'd0;
      mode_q   <= 1'b0;
    end else if (cfg_wr) begin
      case (cpu_addr[14:13])
        2'b00: ram_on_q <= (cpu_wdata[3:0] == 4'hA);
        2'b01: low_q    <= cpu_wdata[4:0];
        2'b10: hi_q     <= cpu_wdata[1:0];
        default: mode_q <= cpu_wdata[0];
      endcase
    end
  end

  wire [4:0] low_eff = (low_q == 5'd0) ? 5'd1 : low_q;
  wire [1:0] rom_hi  = cfg_big_rom ? hi_q : 2'b00;

  logic [BANK_W-1:0] bank;
  always_comb begin
    if (cpu_addr[14])
      bank = {rom_hi, low_eff};
    else if (mode_q)
      bank = {rom_hi, 5'd0};
    else
      bank = '0;
  end

  logic [BANK_W+13:0] rom_full;
  assign rom_full = {bank, cpu_addr[13:0]};
  assign rom_addr = rom_full[ROM_AW-1:0];

  wire [1:0] ram_bank = (cfg_big_ram && mode_q) ? hi_q : 2'b00;
  logic [14:0] ram_full;
  assign ram_full = {ram_bank, cpu_addr[12:0]};
  assign ram_addr = ram_full[RAM_AW-1:0];

  assign ram_ce = ram_on_q && (cpu_addr[15:13] == 3'b101);
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int ROM_AW = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_wr,
  input logic              mode_q,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              ram_ce
);
  // R10
  ce_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> (cpu_addr[15:13] == 3'b101));

  // R2
  ram_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA) |=> !ram_ce);

  // R4
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_wdata[4:0] == 5'd0) |=>
      (cpu_addr[15:14] != 2'b01 || rom_addr[18:14] == 5'd1));

  // R7
  mode0_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_AW-1:14] == '0));

  // R13
  offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> (rom_addr[13:0] == cpu_addr[13:0]));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.ROM_AW(ROM_AW)) chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .mode_q(mode_q), .rom_addr(rom_addr), .ram_ce(ram_ce)
);

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic cpu_wr = 0, cfg_big_rom = 0, cfg_big_ram = 0;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic ram_ce;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  cart_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cfg_big_rom(cfg_big_rom), .cfg_big_ram(cfg_big_ram),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_ce(ram_ce)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic look(input logic [15:0] a);
    cpu_addr = a;
    #1;
  endtask

  task automatic t_reset;
    look(16'h4000); chk("R1 bank1", rom_addr, 21'h04000);
    look(16'h0000); chk("R1 bank0", rom_addr, 21'h0);
    look(16'hA000); chk("R1 ram off", ram_ce, 0);
  endtask

  task automatic t_ram_enable;
    wr(16'h0000, 8'h0A);
    look(16'hA123); chk("R2 enable", ram_ce, 1); chk("R11 addr", ram_addr, 15'h0123);
    look(16'h9FFF); chk("R10 below", ram_ce, 0);
    look(16'hC000); chk("R10 above", ram_ce, 0);
    wr(16'h1FFF, 8'hFA);
    look(16'hBFFF); chk("R2 upper nibble ignored", ram_ce, 1);
    wr(16'h0000, 8'h0B);
    look(16'hA000); chk("R2 disable", ram_ce, 0);
  endtask

  task automatic t_lower;
    wr(16'h2000, 8'hE5);
    look(16'h4000); chk("R3 bank5", rom_addr, 21'h14000);
    wr(16'h3FFF, 8'h00);
    look(16'h7FFF); chk("R4 zero as one", rom_addr, 21'h07FFF);
    wr(16'h2000, 8'h20);
    look(16'h4000); chk("R3/R4 bit5 ignored", rom_addr, 21'h04000);
  endtask

  task automatic t_secondary;
    cfg_big_rom = 1;
    wr(16'h4000, 8'hFD);
    wr(16'h2000, 8'h00);
    look(16'h4000); chk("R5 20h->21h", rom_addr, 21'h084000);
    wr(16'h5FFF, 8'h03);
    wr(16'h2000, 8'h1F);
    look(16'h7FFF); chk("R5 bank7F", rom_addr, 21'h1FFFFF);
    look(16'h0000); chk("R7 mode0 fixed", rom_addr, 21'h0);
  endtask

  task automatic t_mode;
    wr(16'h4000, 8'h02);
    wr(16'h2000, 8'h00);
    wr(16'h6000, 8'h01);
    look(16'h0010); chk("R8 bank40", rom_addr, 21'h100010);
    look(16'h4000); chk("R9 40h->41h", rom_addr, 21'h104000);
    wr(16'h2000, 8'h03);
    look(16'h4000); chk("R9 bank43", rom_addr, 21'h10C000);
    wr(16'h7FFF, 8'hFE);
    look(16'h0010); chk("R6/R7 back to bank0", rom_addr, 21'h000010);
    look(16'h4000); chk("R9 mode0 same", rom_addr, 21'h10C000);
  endtask

  task automatic t_ram_bank;
    cfg_big_rom = 0; cfg_big_ram = 1;
    wr(16'h0000, 8'h0A);
    wr(16'h4000, 8'h03);
    wr(16'h2000, 8'h01);
    look(16'hA005); chk("R11 mode0 bank0", ram_addr, 15'h0005);
    wr(16'h6000, 8'h01);
    look(16'hA005); chk("R11 mode1 bank3", ram_addr, 15'h6005);
    look(16'h0123); chk("R12 lower no remap", rom_addr, 21'h0123);
    look(16'h4000); chk("R12 no high bits", rom_addr, 21'h04000);
  endtask

  task automatic t_ignored;
    wr(16'hA000, 8'h00);
    wr(16'h8000, 8'h00);
    wr(16'hE000, 8'h00);
    look(16'hA005); chk("R13 ram still on", ram_ce, 1);
    chk("R13 bank kept", ram_addr, 15'h6005);
    look(16'h5ABC); chk("R13 offset", rom_addr, 21'h05ABC);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ram_enable();
    t_lower();
    t_secondary();
    t_mode();
    t_ram_bank();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule